// File: doc/BRIEF.md
# Dual-Prescaler Channel Tick Generator

This block turns one input clock into five independent count-enable strobes, one per down-counting timer channel. Two 8-bit prescalers are shared unevenly: the first feeds channels 0 and 1, the second feeds channels 2, 3 and 4. Behind each prescaler, every channel has its own power-of-two post-divider chosen by a 4-bit select field. A channel therefore strobes once every (prescaler + 1) × 2^select clock cycles, with the select saturating at a divide ratio of 16.

Both configuration words are written through a single-cycle write strobe with a one-bit word select, and either word can be read back combinationally. A write that alters a prescaler value or a divider field restarts the counters it affects from zero, so the new rate is seen from the very next cycle and no partly elapsed period of the old rate is ever completed. A write that rewrites an unchanged value disturbs nothing.

Top module: `chan_tick_gen`

## Requirements
- R1: After reset, the prescaler word reads 0x0101 and the divider word reads 0, so every channel strobes once every 2 cycles.
- R2: Word select 0 addresses the prescaler word (16 stored bits) and select 1 the divider word (20 stored bits); read data holds the stored bits in the low positions and zero above them.
- R3: Channels 0 and 1 take their rate from the prescaler in bits [7:0] of the prescaler word; channels 2, 3 and 4 from the one in bits [15:8].
- R4: Channel n's divider select sits in bits [4n+3:4n] of the divider word; a select v from 0 to 4 gives a ratio of 2^v.
- R5: A divider select greater than 4 gives a ratio of 16.
- R6: In steady state, channel n raises its one-cycle strobe every (P+1) × D cycles, where P is its prescaler value and D its divider ratio.
- R7: A write that changes a prescaler value restarts that prescaler and the dividers of all channels it feeds; each such channel's first strobe comes exactly (P+1) × D cycles after the write, counting the cycle that follows the write edge as the first.
- R8: A write that changes channel n's divider select restarts that channel's divider; with a prescaler value of 0 its first strobe comes D cycles after the write, counted as in R7.
- R9: A write that stores a value equal to the current one restarts nothing: the strobe spacing across that write stays at (P+1) × D.
- R10: No strobe is raised by a channel in the cycle in which a write restarts its counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, also the count reference |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 1 | Word written: 0 prescalers, 1 divider selects |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Word read: 0 prescalers, 1 divider selects |
| rd_data | output | 32 | Read data, zero-extended |
| tick | output | 5 | Per-channel one-cycle count-enable strobes |

## Verification
The two functions that meet in one cycle are a strobe that is due and a write that restarts the counters feeding it. The bench provokes this by setting every channel to strobe each cycle and then issuing a prescaler write: all five strobes must be low during the write cycle and each channel must then strobe exactly on the count computed from its new rate. The converse case, a rewrite of an unchanged value placed mid-period, is judged by the strobe spacing across it remaining at the steady-state period.

// File: rtl/tick_gen_pkg.sv
// Shared definitions for the channel tick generator.
// Assumes exactly two prescaler groups; the word-select encoding is fixed.
package tick_gen_pkg;

    // Configuration word selector, used for both writes and reads.
    typedef enum logic {
        REG_PRE = 1'b0,
        REG_DIV = 1'b1
    } cfg_reg_e;

    // Number of shared prescalers.
    localparam int PRE_GROUPS = 2;

endpackage

// File: rtl/tick_prescaler.sv
// Free-running prescaler: counts 0..limit and strobes on the terminal value.
// Assumes the owner asserts clr in the same cycle the limit register changes,
// so the count never exceeds a freshly lowered limit.
module tick_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [PRE_W-1:0] limit,
    output logic             stb
);

    logic [PRE_W-1:0] cnt;
    logic             at_end;

    assign at_end = (cnt == limit);

    // Advance the count, wrapping at the terminal value or restarting on clr.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (at_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Strobe on the terminal value unless a restart is under way.
    assign stb = at_end && !clr;

    AST_PRE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0)); // R7

    AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= limit); // R6

endmodule

// File: rtl/tick_post_div.sv
// Per-channel power-of-two divider: counts prescaler strobes and emits one
// tick for every 2^sel of them, sel saturating at MAX_SEL.
// Assumes clr is raised in the cycle sel or the feeding prescaler changes.
module tick_post_div #(
    parameter int SEL_W   = 4,
    parameter int MAX_SEL = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             stb_in,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    localparam int CW = MAX_SEL;

    logic [SEL_W-1:0] shift;
    logic [CW:0]      ratio;
    logic [CW-1:0]    last;
    logic [CW-1:0]    cnt;

    // Clamp the select and derive the terminal strobe count.
    assign shift = (sel > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : sel;
    assign ratio = (CW+1)'(1) << shift;
    assign last  = CW'(ratio - 1'b1);

    // Count prescaler strobes, wrapping after the last one of a period.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (stb_in) begin
            cnt <= (cnt == last) ? '0 : cnt + 1'b1;
        end
    end

    // Tick on the final strobe of each period.
    assign tick = stb_in && (cnt == last) && !clr;

    AST_DIV_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0)); // R8

    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last); // R5

endmodule

// File: rtl/chan_tick_gen.sv
// Channel tick generator top: holds the prescaler and divider-select words,
// detects value changes on write to restart affected counters, and drives
// one prescaler per group and one post-divider per channel.
// Assumes DATA_W covers both configuration words.
module chan_tick_gen
    import tick_gen_pkg::*;
#(
    parameter int NUM_CH    = 5,
    parameter int PRE_W     = 8,
    parameter int SEL_W     = 4,
    parameter int MAX_SEL   = 4,
    parameter int GROUP0_CH = 2,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_CH-1:0] tick
);

    localparam int W0 = PRE_GROUPS * PRE_W;
    localparam int W1 = NUM_CH * SEL_W;
    localparam logic [W0-1:0] PRE_RST = {PRE_GROUPS{PRE_W'(1)}};

    logic [W0-1:0]         pre_cfg;
    logic [W1-1:0]         div_cfg;
    logic                  wr_pre;
    logic                  wr_div;
    logic [PRE_GROUPS-1:0] pre_clr;
    logic [PRE_GROUPS-1:0] pre_stb;
    logic [NUM_CH-1:0]     div_clr;

    assign wr_pre = wr_en && (wr_sel == REG_PRE);
    assign wr_div = wr_en && (wr_sel == REG_DIV);

    // Store the configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cfg <= PRE_RST;
            div_cfg <= '0;
        end else begin
            if (wr_pre) pre_cfg <= wr_data[W0-1:0];
            if (wr_div) div_cfg <= wr_data[W1-1:0];
        end
    end

    // Return the selected word, zero-extended.
    always_comb begin
        rd_data = '0;
        if (rd_sel == REG_PRE) rd_data[W0-1:0] = pre_cfg;
        else                   rd_data[W1-1:0] = div_cfg;
    end

    for (genvar g = 0; g < PRE_GROUPS; g++) begin : g_pre
        // Restart this prescaler only when its value actually changes.
        assign pre_clr[g] = wr_pre &&
            (wr_data[g*PRE_W +: PRE_W] != pre_cfg[g*PRE_W +: PRE_W]);

        tick_prescaler #(.PRE_W(PRE_W)) u_pre (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (pre_clr[g]),
            .limit (pre_cfg[g*PRE_W +: PRE_W]),
            .stb   (pre_stb[g])
        );
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        localparam int GRP = (n < GROUP0_CH) ? 0 : 1;

        // Restart on a changed select or a restart of the feeding prescaler.
        assign div_clr[n] = pre_clr[GRP] || (wr_div &&
            (wr_data[n*SEL_W +: SEL_W] != div_cfg[n*SEL_W +: SEL_W]));

        tick_post_div #(.SEL_W(SEL_W), .MAX_SEL(MAX_SEL)) u_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (div_clr[n]),
            .stb_in (pre_stb[GRP]),
            .sel    (div_cfg[n*SEL_W +: SEL_W]),
            .tick   (tick[n])
        );
    end

    AST_RESET_CFG: assert property (@(posedge clk)
        !rst_n |=> (pre_cfg == PRE_RST && div_cfg == '0)); // R1

    AST_QUIET_ON_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (div_clr & tick) == '0); // R10

    AST_SAME_NO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pre && wr_data[W0-1:0] == pre_cfg) |-> (pre_clr == '0)); // R9

    AST_RD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == REG_PRE) |-> (rd_data[DATA_W-1:W0] == '0)); // R2

endmodule

// File: tb/tb_chan_tick_gen.sv
// Sweeps prescaler and divider settings, checks strobe spacing, restart
// latency, same-value rewrites and the restart-cycle quiet rule.
module tb_chan_tick_gen;

    localparam int NCH = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic [NCH-1:0] tick;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    int last_t [NCH];
    int gap    [NCH];
    int first_t[NCH];

    chan_tick_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .tick(tick)
    );

    always #2 clk = ~clk;

    // Strobe spacing monitor, sampled after each falling edge.
    initial begin
        for (int c = 0; c < NCH; c++) begin last_t[c] = 0; gap[c] = 0; end
        forever begin
            @(negedge clk); #1;
            cyc++;
            for (int c = 0; c < NCH; c++)
                if (tick[c]) begin gap[c] = cyc - last_t[c]; last_t[c] = cyc; end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int ratio(input int s);
        return 1 << ((s > 4) ? 4 : s);
    endfunction

    // Record each channel's first strobe, k=1 being the cycle after the write.
    task automatic first_ticks(input int maxk);
        for (int c = 0; c < NCH; c++) first_t[c] = 0;
        for (int k = 1; k <= maxk; k++) begin
            #1;
            for (int c = 0; c < NCH; c++)
                if (tick[c] && first_t[c] == 0) first_t[c] = k;
            @(negedge clk);
        end
    endtask

    initial begin
        #(4 * 200000);
        n_errors++; n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int sv[8];
        int pv[3];
        sv = '{0, 1, 2, 3, 4, 5, 7, 15};
        pv = '{0, 1, 3};

        idle(3);
        rst_n = 1'b1;

        // R1: reset state readback and strobe spacing.
        rd_sel = 1'b0; #1;
        check(rd_data == 32'h0101, "R1 word0 reset", rd_data, 32'h0101);
        rd_sel = 1'b1; #1;
        check(rd_data == 32'h0, "R1 word1 reset", rd_data, 0);
        idle(10);
        for (int c = 0; c < NCH; c++) check(gap[c] == 2, "R1 reset period", gap[c], 2);

        // R2: readback and zero upper bits.
        wr(1'b0, 32'hFFFF_A5C3);
        wr(1'b1, 32'hFFF1_2345);
        rd_sel = 1'b0; #1;
        check(rd_data == 32'h0000_A5C3, "R2 word0 readback", rd_data, 32'h0000_A5C3);
        rd_sel = 1'b1; #1;
        check(rd_data == 32'h0001_2345, "R2 word1 readback", rd_data, 32'h0001_2345);

        // R3 R4 R5 R6: sweep of prescaler pairs and per-channel selects.
        foreach (pv[pi]) begin
            for (int i = 0; i < 8; i++) begin
                logic [31:0] w1;
                int p0, p1;
                p0 = pv[pi]; p1 = pv[pi] + 1;
                w1 = '0;
                for (int c = 0; c < NCH; c++) w1 |= 32'(sv[(i + c) % 8]) << (4 * c);
                wr(1'b0, 32'((p1 << 8) | p0));
                wr(1'b1, w1);
                idle(170);
                for (int c = 0; c < NCH; c++) begin
                    int s, e;
                    s = sv[(i + c) % 8];
                    e = ((c < 2) ? p0 + 1 : p1 + 1) * ratio(s);
                    if (s > 4) check(gap[c] == e, "R5 saturated period", gap[c], e);
                    else if (c < 2) check(gap[c] == e, "R3 R4 R6 group0 period", gap[c], e);
                    else check(gap[c] == e, "R3 R4 R6 group1 period", gap[c], e);
                end
            end
        end

        // R9: rewrite of an unchanged prescaler word mid-period.
        wr(1'b0, 32'h0202);
        wr(1'b1, 32'h11111);
        idle(30);
        while (!tick[0]) @(negedge clk);
        idle(1);
        wr(1'b0, 32'h0202);
        while (!tick[0]) @(negedge clk);
        #2;
        check(gap[0] == 6, "R9 spacing across same-value write", gap[0], 6);
        check(gap[3] == 6, "R9 spacing group1", gap[3], 6);

        // R10 and R7: all channels strobe every cycle, then a prescaler change.
        wr(1'b0, 32'h0000);
        wr(1'b1, 32'h00000);
        idle(4);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h0201;
        #1;
        check(tick == '0, "R10 quiet in restart cycle", tick, 0);
        @(negedge clk);
        wr_en = 1'b0;
        first_ticks(20);
        for (int c = 0; c < NCH; c++) begin
            int e;
            e = (c < 2) ? 2 : 3;
            check(first_t[c] == e, "R7 first strobe after prescaler change", first_t[c], e);
        end

        // R8: divider select change with prescaler 0.
        wr(1'b0, 32'h0000);
        wr(1'b1, 32'h11111);
        idle(5);
        wr(1'b1, 32'h33333);
        first_ticks(20);
        for (int c = 0; c < NCH; c++)
            check(first_t[c] == 8, "R8 first strobe after select change", first_t[c], 8);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule